// File: doc/BRIEF.md
# Presence-Detect Image Checker

This block inspects the contents of a memory module's presence-detect EEPROM as it is read out by a separate serial-bus master. Each byte reaches the block with its address in the EEPROM. The block keeps a running 8-bit sum for the checksum and records which addresses it has already seen. It also captures, on the fly, the fields a memory controller needs to program itself: row and column address widths, rank count, banks per device, the CAS-latency and burst-length support maps, and the density of each rank.

Only addresses 0 to 63 take part. The order of arrival is free. Once every one of those 64 addresses has been received, the block spends one cycle evaluating the image and then reports. It raises `done` together with exactly one of `valid` or `error`, and a four-bit cause vector shows why an image was rejected. A synchronous `clear` empties the block so that the next module can be checked.

The controller is a small state machine with three named states. COLLECT accepts bytes. The transition COLLECT→EVALUATE is taken when the address bitmap becomes full. EVALUATE→REPORT is taken unconditionally one cycle later, and that is when the cause vector is registered. REPORT holds until `clear`, which takes any state back to COLLECT.

Top module: `spd_checker`

## Requirements
- R1: After reset or after a clear, `done`, `valid` and `error` are low, `err_flags` is zero and all captured field outputs are zero.
- R2: `done` is low until every address 0 to 63 has been accepted. It goes high two clock edges after the edge that accepts the last missing address, and it stays high until a clear.
- R3: `err_flags[0]` (checksum) is set when byte 63 differs from the low 8 bits of the sum of bytes 0 to 62.
- R4: `err_flags[1]` (memory type) is set when byte 2 is not 0x04.
- R5: `err_flags[2]` (geometry) is set when byte 3 is outside 11 to 12, or when byte 4 is outside 8 to 10. These bounds are parameters.
- R6: `err_flags[3]` (duplicate) is set when an address in 0 to 63 arrives a second time before `done`. The data of the repeated byte is discarded: it changes neither the sum nor any field.
- R7: While `done` is high, exactly one of `valid` and `error` is high, and `error` is high exactly when `err_flags` is nonzero. While `done` is low, both are low.
- R8: The field outputs are taken from these bytes: `row_bits` = byte 3, `col_bits` = byte 4, `rank_count` = byte 5, `burst_map` = byte 16, `bank_count` = byte 17, `cas_map` = byte 18. `density_mb` = byte 31 × 4.
- R9: Bytes with an address of 64 to 255 have no effect on any output.
- R10: Addresses 0 to 63 may arrive in any order, and the result does not depend on that order.
- R11: After `done`, further bytes are ignored until a clear. Outputs and flags hold.
- R12: `clear` is synchronous and takes priority over a byte presented in the same cycle, which is then dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous restart for a new image |
| in_valid | input | 1 | A byte is presented this cycle |
| in_index | input | 8 | EEPROM address of the byte |
| in_data | input | 8 | Byte value |
| done | output | 1 | Image complete and evaluated |
| valid | output | 1 | Image accepted (with done) |
| error | output | 1 | Image rejected (with done) |
| err_flags | output | 4 | Cause: bit0 checksum, bit1 type, bit2 geometry, bit3 duplicate |
| row_bits | output | 8 | Row address bits |
| col_bits | output | 8 | Column address bits |
| rank_count | output | 8 | Module ranks |
| bank_count | output | 8 | Banks per device |
| cas_map | output | 8 | CAS latency support map |
| burst_map | output | 8 | Burst length support map |
| density_mb | output | 10 | Rank density in MB |

## Verification
The bench goes after the cases where the outcome hinges on a single value. Row and column widths are driven exactly at their limits and one step past them: an off-by-one bound in the range check would reject a legal module or accept an illegal one. A repeated address is sent carrying altered data. A design that overwrote the byte or added it to the sum again would report a checksum error or wrong fields, instead of only the duplicate cause. Other streams carry addresses above 63, bytes sent after `done`, and a byte presented in the same cycle as `clear`. A design that leaked any of these into its state would show changed fields, an early or held-over `done`, or a rejected image.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam int BYTE_W = 8;

    localparam int POS_TYPE    = 2;
    localparam int POS_ROWS    = 3;
    localparam int POS_COLS    = 4;
    localparam int POS_RANKS   = 5;
    localparam int POS_BURST   = 16;
    localparam int POS_BANKS   = 17;
    localparam int POS_CAS     = 18;
    localparam int POS_DENSITY = 31;

    localparam logic [BYTE_W-1:0] TYPE_SDRAM = 8'h04;

    localparam int ERR_W    = 4;
    localparam int ERR_CSUM = 0;
    localparam int ERR_TYPE = 1;
    localparam int ERR_GEOM = 2;
    localparam int ERR_DUP  = 3;

    typedef enum logic [1:0] {
        ST_COLLECT  = 2'd0,
        ST_EVALUATE = 2'd1,
        ST_REPORT   = 2'd2
    } chk_state_e;

    typedef struct packed {
        logic [BYTE_W-1:0] mem_type;
        logic [BYTE_W-1:0] rows;
        logic [BYTE_W-1:0] cols;
        logic [BYTE_W-1:0] ranks;
        logic [BYTE_W-1:0] burst;
        logic [BYTE_W-1:0] banks;
        logic [BYTE_W-1:0] cas;
        logic [BYTE_W-1:0] density;
    } spd_fields_t;
endpackage

// File: rtl/spd_index_tracker.sv
module spd_index_tracker #(
    parameter int NUM_BYTES = 64,
    parameter int IDX_W     = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             accept,
    input  logic [IDX_W-1:0] idx,
    output logic             new_byte,
    output logic             dup_seen,
    output logic             all_seen
);
    localparam int LOC_W = $clog2(NUM_BYTES);

    logic [NUM_BYTES-1:0] seen_q;
    logic                 dup_q;
    logic                 in_range;
    logic                 hit;

    assign in_range = idx < IDX_W'(NUM_BYTES);
    assign hit      = seen_q[idx[LOC_W-1:0]];
    assign new_byte = accept && in_range && !hit;
    assign all_seen = &seen_q;
    assign dup_seen = dup_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q <= '0;
            dup_q  <= 1'b0;
        end else if (clear) begin
            seen_q <= '0;
            dup_q  <= 1'b0;
        end else if (accept && in_range) begin
            if (hit) begin
                dup_q <= 1'b1;
            end else begin
                seen_q[idx[LOC_W-1:0]] <= 1'b1;
            end
        end
    end

    // R6: a recorded duplicate is never forgotten before a clear
    assert_dup_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dup_q && !clear) |=> dup_q);

    // R2: the bitmap only grows while no clear is applied
    assert_bitmap_monotonic_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (all_seen && !clear) |=> all_seen);
endmodule

// File: rtl/spd_accumulator.sv
module spd_accumulator #(
    parameter int NUM_BYTES = 64,
    parameter int IDX_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       new_byte,
    input  logic [IDX_W-1:0]           idx,
    input  logic [spd_pkg::BYTE_W-1:0] data,
    output logic [spd_pkg::BYTE_W-1:0] sum,
    output logic [spd_pkg::BYTE_W-1:0] stored_csum
);
    import spd_pkg::*;

    localparam logic [IDX_W-1:0] CSUM_POS = IDX_W'(NUM_BYTES - 1);

    logic [BYTE_W-1:0] sum_q;
    logic [BYTE_W-1:0] csum_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sum_q  <= '0;
            csum_q <= '0;
        end else if (clear) begin
            sum_q  <= '0;
            csum_q <= '0;
        end else if (new_byte) begin
            if (idx == CSUM_POS) begin
                csum_q <= data;
            end else begin
                sum_q <= sum_q + data;
            end
        end
    end

    assign sum         = sum_q;
    assign stored_csum = csum_q;

    // R9: only first arrivals of in-range addresses move the running sum
    assert_sum_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_byte && !clear) |=> $stable(sum_q));
endmodule

// File: rtl/spd_field_capture.sv
module spd_field_capture #(
    parameter int IDX_W = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       new_byte,
    input  logic [IDX_W-1:0]           idx,
    input  logic [spd_pkg::BYTE_W-1:0] data,
    output spd_pkg::spd_fields_t       fields
);
    import spd_pkg::*;

    spd_fields_t f_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q <= '0;
        end else if (clear) begin
            f_q <= '0;
        end else if (new_byte) begin
            if (idx == IDX_W'(POS_TYPE))    f_q.mem_type <= data;
            if (idx == IDX_W'(POS_ROWS))    f_q.rows     <= data;
            if (idx == IDX_W'(POS_COLS))    f_q.cols     <= data;
            if (idx == IDX_W'(POS_RANKS))   f_q.ranks    <= data;
            if (idx == IDX_W'(POS_BURST))   f_q.burst    <= data;
            if (idx == IDX_W'(POS_BANKS))   f_q.banks    <= data;
            if (idx == IDX_W'(POS_CAS))     f_q.cas      <= data;
            if (idx == IDX_W'(POS_DENSITY)) f_q.density  <= data;
        end
    end

    assign fields = f_q;

    // R6: a repeated or ignored byte never rewrites a captured field
    assert_fields_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!new_byte && !clear) |=> $stable(f_q));
endmodule

// File: rtl/spd_checker.sv
module spd_checker #(
    parameter int NUM_BYTES = 64,
    parameter int IDX_W     = 8,
    parameter int ROW_MIN   = 11,
    parameter int ROW_MAX   = 12,
    parameter int COL_MIN   = 8,
    parameter int COL_MAX   = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           in_valid,
    input  logic [IDX_W-1:0]               in_index,
    input  logic [spd_pkg::BYTE_W-1:0]     in_data,
    output logic                           done,
    output logic                           valid,
    output logic                           error,
    output logic [spd_pkg::ERR_W-1:0]      err_flags,
    output logic [spd_pkg::BYTE_W-1:0]     row_bits,
    output logic [spd_pkg::BYTE_W-1:0]     col_bits,
    output logic [spd_pkg::BYTE_W-1:0]     rank_count,
    output logic [spd_pkg::BYTE_W-1:0]     bank_count,
    output logic [spd_pkg::BYTE_W-1:0]     cas_map,
    output logic [spd_pkg::BYTE_W-1:0]     burst_map,
    output logic [spd_pkg::BYTE_W+1:0]     density_mb
);
    import spd_pkg::*;

    chk_state_e        state_q, state_d;
    logic              accept;
    logic              new_byte;
    logic              dup_seen;
    logic              all_seen;
    logic [BYTE_W-1:0] sum;
    logic [BYTE_W-1:0] stored_csum;
    spd_fields_t       fields;
    logic [ERR_W-1:0]  err_q;
    logic [ERR_W-1:0]  err_calc;

    assign accept = in_valid && !clear && (state_q == ST_COLLECT);

    spd_index_tracker #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_track (
        .clk(clk), .rst_n(rst_n), .clear(clear), .accept(accept),
        .idx(in_index), .new_byte(new_byte), .dup_seen(dup_seen),
        .all_seen(all_seen)
    );

    spd_accumulator #(.NUM_BYTES(NUM_BYTES), .IDX_W(IDX_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clear(clear), .new_byte(new_byte),
        .idx(in_index), .data(in_data), .sum(sum), .stored_csum(stored_csum)
    );

    spd_field_capture #(.IDX_W(IDX_W)) u_fields (
        .clk(clk), .rst_n(rst_n), .clear(clear), .new_byte(new_byte),
        .idx(in_index), .data(in_data), .fields(fields)
    );

    // next state
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_COLLECT;
        end else begin
            unique case (state_q)
                ST_COLLECT:  if (all_seen) state_d = ST_EVALUATE;
                ST_EVALUATE: state_d = ST_REPORT;
                ST_REPORT:   state_d = ST_REPORT;
                default:     state_d = ST_COLLECT;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_COLLECT;
        else        state_q <= state_d;
    end

    // consistency checks, evaluated once the image is complete
    always_comb begin
        err_calc           = '0;
        err_calc[ERR_CSUM] = (sum != stored_csum);
        err_calc[ERR_TYPE] = (fields.mem_type != TYPE_SDRAM);
        err_calc[ERR_GEOM] = (fields.rows < BYTE_W'(ROW_MIN)) || (fields.rows > BYTE_W'(ROW_MAX)) ||
                             (fields.cols < BYTE_W'(COL_MIN)) || (fields.cols > BYTE_W'(COL_MAX));
        err_calc[ERR_DUP]  = dup_seen;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                        err_q <= '0;
        else if (clear)                    err_q <= '0;
        else if (state_q == ST_EVALUATE)   err_q <= err_calc;
    end

    // outputs
    always_comb begin
        done       = (state_q == ST_REPORT);
        error      = done && (|err_q);
        valid      = done && !(|err_q);
        err_flags  = err_q;
        row_bits   = fields.rows;
        col_bits   = fields.cols;
        rank_count = fields.ranks;
        bank_count = fields.banks;
        cas_map    = fields.cas;
        burst_map  = fields.burst;
        density_mb = {fields.density, 2'b00};
    end

    assert_done_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> done);

    assert_verdict_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (valid != error));

    assert_no_verdict_early_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (!valid && !error));

    assert_report_frozen_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !clear) |=> ($stable(err_flags) && $stable(row_bits) && $stable(density_mb)));

    assert_clear_restarts_R12: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (!done && err_flags == '0));
endmodule

// File: tb/tb_spd_checker.sv
module tb_spd_checker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_index = '0;
    logic [7:0] in_data = '0;
    logic       done, valid, error;
    logic [3:0] err_flags;
    logic [7:0] row_bits, col_bits, rank_count, bank_count, cas_map, burst_map;
    logic [9:0] density_mb;

    int checks = 0;
    int errors = 0;
    logic [7:0] img [64];
    int perm [64];

    always #2 clk = ~clk;

    spd_checker dut (
        .clk(clk), .rst_n(rst_n), .clear(clear), .in_valid(in_valid),
        .in_index(in_index), .in_data(in_data), .done(done), .valid(valid),
        .error(error), .err_flags(err_flags), .row_bits(row_bits),
        .col_bits(col_bits), .rank_count(rank_count), .bank_count(bank_count),
        .cas_map(cas_map), .burst_map(burst_map), .density_mb(density_mb)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] idx, input logic [7:0] d);
        @(negedge clk);
        in_valid = 1'b1; in_index = idx; in_data = d;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic do_clear(input bit with_byte);
        @(negedge clk);
        clear = 1'b1;
        if (with_byte) begin
            in_valid = 1'b1; in_index = 8'd3; in_data = 8'h77;
        end
        @(negedge clk);
        clear = 1'b0; in_valid = 1'b0;
    endtask

    function automatic void fix_csum();
        logic [7:0] s = 8'h00;
        for (int k = 0; k < 63; k++) s = s + img[k];
        img[63] = s;
    endfunction

    function automatic void build(input logic [7:0] rows, input logic [7:0] cols);
        for (int k = 0; k < 64; k++) img[k] = 8'($urandom);
        img[0] = 8'h80; img[1] = 8'h08; img[2] = 8'h04;
        img[3] = rows; img[4] = cols; img[5] = 8'(1 + $urandom % 2);
        img[16] = 8'h8F; img[17] = 8'(2 + 2 * ($urandom % 2)); img[18] = 8'h06;
        img[31] = 8'h04 << ($urandom % 4);
        fix_csum();
    endfunction

    function automatic logic [3:0] exp_flags(input bit dup);
        logic [7:0] s = 8'h00;
        logic [3:0] f;
        for (int k = 0; k < 63; k++) s = s + img[k];
        f[0] = (s != img[63]);
        f[1] = (img[2] != 8'h04);
        f[2] = (img[3] < 8'd11) || (img[3] > 8'd12) || (img[4] < 8'd8) || (img[4] > 8'd10);
        f[3] = dup;
        return f;
    endfunction

    // R10: random order of addresses 0..63; R9: junk addresses mixed in
    task automatic send_image(input bit shuffle, input bit junk, input int dup_at);
        for (int k = 0; k < 64; k++) perm[k] = k;
        if (shuffle) begin
            for (int k = 63; k > 0; k--) begin
                int j = int'($urandom % (k + 1));
                int t = perm[k];
                perm[k] = perm[j]; perm[j] = t;
            end
        end
        for (int k = 0; k < 64; k++) begin
            if (k == 63) chk(done == 1'b0, "R2 done before last byte", done, 0);
            send(8'(perm[k]), img[perm[k]]);
            if (k < 63 && junk && ($urandom % 3 == 0))
                send(8'(64 + $urandom % 192), 8'($urandom));
            if (k == dup_at) send(8'(perm[0]), img[perm[0]] ^ 8'h5A);
        end
    endtask

    task automatic check_result(input bit dup);
        logic [3:0] f = exp_flags(dup);
        chk(done == 1'b0, "R2 done one edge after last", done, 0);
        @(negedge clk);
        chk(done == 1'b0, "R2 done two edges after last", done, 0);
        @(negedge clk);
        chk(done == 1'b1, "R2 done raised", done, 1);
        chk(err_flags == f, "R3 R4 R5 R6 err_flags", err_flags, f);
        chk(error == (|f) && valid == !(|f), "R7 verdict", {valid, error}, {!(|f), |f});
        chk(row_bits == img[3] && col_bits == img[4], "R8 geometry fields",
            {row_bits, col_bits}, {img[3], img[4]});
        chk(rank_count == img[5] && bank_count == img[17], "R8 rank/bank fields",
            {rank_count, bank_count}, {img[5], img[17]});
        chk(cas_map == img[18] && burst_map == img[16], "R8 maps",
            {cas_map, burst_map}, {img[18], img[16]});
        chk(density_mb == {img[31], 2'b00}, "R8 density", density_mb, {img[31], 2'b00});
    endtask

    task automatic run(input bit shuffle, input bit junk, input int dup_at);
        do_clear(1'b0);
        send_image(shuffle, junk, dup_at);
        check_result(dup_at >= 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!done && !valid && !error && err_flags == 0, "R1 reset verdict",
            {done, valid, error, err_flags}, 0);
        chk(row_bits == 0 && density_mb == 0 && cas_map == 0, "R1 reset fields",
            {row_bits, density_mb}, 0);

        // in-order good image, R8 / R10
        build(8'd12, 8'd9);
        run(1'b0, 1'b0, -1);

        // R11: bytes after done are ignored
        send(8'd3, 8'hEE);
        send(8'd31, 8'h01);
        chk(done && row_bits == 8'd12 && density_mb == {img[31], 2'b00}, "R11 post-done bytes",
            {done, row_bits}, {1'b1, 8'd12});

        // R1 / R12 clear after done
        do_clear(1'b0);
        chk(!done && !valid && err_flags == 0 && row_bits == 0, "R1 R12 clear after done",
            {done, row_bits}, 0);

        // R5 geometry bounds
        build(8'd11, 8'd8);  run(1'b1, 1'b0, -1);
        build(8'd12, 8'd10); run(1'b1, 1'b0, -1);
        build(8'd10, 8'd9);  run(1'b1, 1'b0, -1);
        build(8'd13, 8'd9);  run(1'b1, 1'b0, -1);
        build(8'd11, 8'd7);  run(1'b1, 1'b0, -1);
        build(8'd12, 8'd11); run(1'b1, 1'b0, -1);

        // R4 wrong type with a correct checksum
        build(8'd12, 8'd9); img[2] = 8'h02; fix_csum();
        run(1'b1, 1'b0, -1);

        // R3 checksum off by one
        build(8'd12, 8'd9); img[63] = img[63] + 8'd1;
        run(1'b1, 1'b0, -1);

        // R6 duplicate with altered data, R9 junk addresses
        build(8'd12, 8'd9);
        run(1'b1, 1'b1, 30);

        // R9 junk only: nothing moves
        do_clear(1'b0);
        for (int k = 0; k < 20; k++) send(8'(64 + $urandom % 192), 8'($urandom));
        repeat (3) @(negedge clk);
        chk(!done && row_bits == 0 && density_mb == 0 && cas_map == 0, "R9 high addresses ignored",
            {done, row_bits}, 0);

        // R12 clear with simultaneous byte, mid-stream
        build(8'd11, 8'd10);
        for (int k = 0; k < 20; k++) send(8'(k), img[k]);
        do_clear(1'b1);
        chk(row_bits == 0 && !done, "R12 clear drops same-cycle byte", row_bits, 0);
        send_image(1'b1, 1'b0, -1);
        check_result(1'b0);

        // constrained random mix, R10
        for (int n = 0; n < 24; n++) begin
            build(8'(10 + $urandom % 4), 8'(7 + $urandom % 5));
            if ($urandom % 4 == 0) begin img[2] = 8'($urandom); fix_csum(); end
            if ($urandom % 4 == 0) img[63] = img[63] ^ 8'(1 + $urandom % 255);
            run(1'b1, ($urandom % 2) == 1, ($urandom % 5 == 0) ? 40 : -1);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule